// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the chip-enable-qualified accesses arriving at a nonvolatile-shadowed SRAM and looks for one fixed unlock key: six reads in a row at particular 13-bit addresses. The first five addresses are shared. The sixth one chooses the command. When the last read lands on the store address, the block raises a one-cycle `store_cmd`. When it lands on the recall address, the block raises a one-cycle `recall_cmd`. In the same cycle it asserts `bus_hiz`, which tells the memory to put its data bus into high impedance and ignore the host. `bus_hiz` stays high until the store/recall controller has raised `nv_busy` and then dropped it again.

Each access is one strobe, `acc_valid`, sampled on a rising clock edge. It carries an address and a write flag. The output-enable state plays no part, so a read counts whether or not its data is driven. The access stream has no ready signal and no back-pressure: every strobe is taken in the cycle it is presented. Cycles with `acc_valid` low are not accesses and leave the progress untouched. Any write, or any read away from the expected address, throws the progress away. The one exception is a read at the first key address: it does not discard the progress entirely but counts as the first step of a new attempt. The read data path and the nonvolatile transfer itself belong to other blocks.

Top module: `cmdseq_detector`

## Requirements
- R1: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, with no other access between them, make `store_cmd` high for the single cycle after the clock edge that samples the sixth read.
- R2: The same five first reads followed by a read at 0x0F0E make `recall_cmd` high for the single cycle after the sixth read's edge, and `store_cmd` stays low.
- R3: An access with `acc_wr`=1 (a write) at any step aborts the attempt. No command follows until a complete new six-read key has been seen.
- R4: A read at an address other than the expected one aborts the attempt. If that read is at 0x0000 it counts as step one of a fresh attempt, so five more correct reads complete the key.
- R5: `bus_hiz` goes high in the same cycle as either command pulse. It stays high while `nv_busy` has not yet risen and while `nv_busy` is high. It drops in the cycle after the first clock edge that samples `nv_busy` low after it had been high.
- R6: `store_cmd` and `recall_cmd` are never high together, and neither is high in two consecutive cycles.
- R7: While `nv_busy`=1, strobes are ignored and the progress returns to idle. No command is issued from an access sampled with `nv_busy` high, and a sequence cut by a busy cycle must restart from 0x0000.
- R8: Cycles with `acc_valid`=0 neither advance nor abort the progress, so idle gaps inside the key are allowed.
- R9: While `rst_n` is low, and right after it is released, `store_cmd`, `recall_cmd` and `bus_hiz` are 0 and the progress is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One access is presented this cycle (always accepted) |
| acc_addr | input | 13 | Address of the access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| nv_busy | input | 1 | Store/recall controller is running a transfer |
| store_cmd | output | 1 | One-cycle store request |
| recall_cmd | output | 1 | One-cycle recall request |
| bus_hiz | output | 1 | Disable the data bus and the host interface |

## Verification
The hardest situation to reach from the ports is a long partial match that is cut short: a fifth-step progress hit by a write, by a busy cycle, or by a stray 0x0000 read, with the restart rule then deciding whether the next five reads complete the key. Random addresses almost never reach that depth, so the random generator picks the address expected at the model's current step most of the time. It mixes in sparse writes, 0x0000 reads, idle gaps and `nv_busy` bursts. Directed sequences cover the aborts at specific steps, and the output-disable window as the controller's busy rises and falls.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  localparam int unsigned ADDR_W     = 13;
  localparam int unsigned PREFIX_LEN = 5;
  localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [STEP_W-1:0] step_t;

  localparam addr_t STORE_KEY  = 13'h0F0F;
  localparam addr_t RECALL_KEY = 13'h0F0E;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_STORE  = 2'd1,
    CMD_RECALL = 2'd2
  } cmd_e;

  typedef enum logic [1:0] {
    HZ_IDLE = 2'd0,
    HZ_WAIT = 2'd1,
    HZ_HOLD = 2'd2
  } hiz_state_e;

  // Shared prefix of the unlock key, indexed by step number.
  function automatic addr_t prefix_key(int unsigned idx);
    case (idx)
      0:       prefix_key = 13'h0000;
      1:       prefix_key = 13'h1555;
      2:       prefix_key = 13'h0AAA;
      3:       prefix_key = 13'h1FFF;
      4:       prefix_key = 13'h10F0;
      default: prefix_key = 13'h0000;
    endcase
  endfunction

endpackage

// File: rtl/cmdseq_addr_match.sv
module cmdseq_addr_match
  import cmdseq_pkg::*;
#(
  parameter int unsigned N_PREFIX = PREFIX_LEN
) (
  input  addr_t               addr,
  output logic [N_PREFIX-1:0] prefix_hit,
  output logic                store_hit,
  output logic                recall_hit
);

  // One comparator per step of the prefix.
  for (genvar g = 0; g < N_PREFIX; g++) begin : g_prefix
    assign prefix_hit[g] = (addr == prefix_key(g));
  end

  assign store_hit  = (addr == STORE_KEY);
  assign recall_hit = (addr == RECALL_KEY);

endmodule

// File: rtl/cmdseq_tracker.sv
module cmdseq_tracker
  import cmdseq_pkg::*;
#(
  parameter int unsigned N_PREFIX = PREFIX_LEN,
  localparam int unsigned SW      = $clog2(N_PREFIX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_wr,
  input  logic                nv_busy,
  input  logic [N_PREFIX-1:0] prefix_hit,
  input  logic                store_hit,
  input  logic                recall_hit,
  output cmd_e                fire
);

  localparam logic [SW-1:0] LAST_STEP = SW'(N_PREFIX);

  logic [SW-1:0]       step_q, step_d;
  logic [N_PREFIX-1:0] step_sel;
  logic                expected_hit;
  logic                restart;

  // One-hot view of the current step, used to pick its comparator.
  always_comb begin
    for (int i = 0; i < N_PREFIX; i++) begin
      step_sel[i] = (step_q == SW'(i));
    end
  end

  assign expected_hit = |(prefix_hit & step_sel);
  assign restart      = prefix_hit[0];

  always_comb begin
    step_d = step_q;
    fire   = CMD_NONE;
    if (nv_busy) begin
      step_d = '0;
    end else if (acc_valid) begin
      if (acc_wr) begin
        step_d = '0;
      end else if (step_q == LAST_STEP) begin
        if (store_hit) begin
          fire   = CMD_STORE;
          step_d = '0;
        end else if (recall_hit) begin
          fire   = CMD_RECALL;
          step_d = '0;
        end else begin
          step_d = restart ? SW'(1) : '0;
        end
      end else if (expected_hit) begin
        step_d = step_q + SW'(1);
      end else begin
        step_d = restart ? SW'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  AST_BUSY_CLEARS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> (step_q == '0)); // R7

  AST_WRITE_CLEARS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_wr) |=> (step_q == '0)); // R3

  AST_IDLE_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !nv_busy) |=> $stable(step_q)); // R8

  AST_FIRE_AFTER_FULL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != CMD_NONE) |-> (step_q == LAST_STEP && acc_valid && !acc_wr && !nv_busy)); // R1

endmodule

// File: rtl/cmdseq_pulse.sv
module cmdseq_pulse
  import cmdseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e fire,
  output logic store_cmd,
  output logic recall_cmd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_cmd  <= 1'b0;
      recall_cmd <= 1'b0;
    end else begin
      store_cmd  <= (fire == CMD_STORE);
      recall_cmd <= (fire == CMD_RECALL);
    end
  end

  AST_CMD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_cmd && recall_cmd)); // R6

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_cmd |=> !store_cmd); // R6

  AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    recall_cmd |=> !recall_cmd); // R6

endmodule

// File: rtl/cmdseq_hiz_ctrl.sv
module cmdseq_hiz_ctrl
  import cmdseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_fire,
  input  logic nv_busy,
  output logic bus_hiz
);

  hiz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cmd_fire) begin
      state_d = HZ_WAIT;
    end else begin
      case (state_q)
        HZ_WAIT: if (nv_busy)  state_d = HZ_HOLD;
        HZ_HOLD: if (!nv_busy) state_d = HZ_IDLE;
        default: state_d = HZ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HZ_IDLE;
    else        state_q <= state_d;
  end

  assign bus_hiz = (state_q != HZ_IDLE);

  AST_HIZ_KEPT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && nv_busy) |=> bus_hiz); // R5

  AST_HIZ_WAITS_FOR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_hiz && !nv_busy && state_q == HZ_WAIT) |=> bus_hiz); // R5

endmodule

// File: rtl/cmdseq_detector.sv
module cmdseq_detector
  import cmdseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic              nv_busy,
  output logic              store_cmd,
  output logic              recall_cmd,
  output logic              bus_hiz
);

  logic [PREFIX_LEN-1:0] prefix_hit;
  logic                  store_hit;
  logic                  recall_hit;
  cmd_e                  fire;

  cmdseq_addr_match #(.N_PREFIX(PREFIX_LEN)) u_match (
    .addr       (acc_addr),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit)
  );

  cmdseq_tracker #(.N_PREFIX(PREFIX_LEN)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_wr     (acc_wr),
    .nv_busy    (nv_busy),
    .prefix_hit (prefix_hit),
    .store_hit  (store_hit),
    .recall_hit (recall_hit),
    .fire       (fire)
  );

  cmdseq_pulse u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .store_cmd  (store_cmd),
    .recall_cmd (recall_cmd)
  );

  cmdseq_hiz_ctrl u_hiz (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (fire != CMD_NONE),
    .nv_busy  (nv_busy),
    .bus_hiz  (bus_hiz)
  );

  AST_HIZ_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd || recall_cmd) |-> bus_hiz); // R5

  AST_NO_CMD_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> !(store_cmd || recall_cmd)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(store_cmd || recall_cmd || bus_hiz)); // R9

endmodule

// File: tb/cmdseq_detector_tb.sv
module cmdseq_detector_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [12:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic        nv_busy = 1'b0;
  logic        store_cmd, recall_cmd, bus_hiz;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench reference state
  int m_step = 0;   // reads matched so far, 0..5
  int m_hz   = 0;   // 0 idle, 1 waiting for busy, 2 in busy

  always #5 clk = ~clk;

  cmdseq_detector dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .nv_busy(nv_busy), .store_cmd(store_cmd),
    .recall_cmd(recall_cmd), .bus_hiz(bus_hiz)
  );

  // Key table: 0..4 shared prefix, 5 store, 6 recall.
  function automatic logic [12:0] key(int i);
    case (i)
      0: return 13'h0000;
      1: return 13'h1555;
      2: return 13'h0AAA;
      3: return 13'h1FFF;
      4: return 13'h10F0;
      5: return 13'h0F0F;
      default: return 13'h0F0E;
    endcase
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock cycle: drive at negedge, update model, compare at next negedge.
  task automatic cycle(bit v, logic [12:0] a, bit wr, bit busy, string tag);
    bit es, er;
    es = 0; er = 0;
    acc_valid = v; acc_addr = a; acc_wr = wr; nv_busy = busy;
    if (busy) begin
      m_step = 0;
    end else if (v) begin
      if (wr) m_step = 0;
      else if (m_step == 5) begin
        if (a == key(5)) es = 1;
        else if (a == key(6)) er = 1;
        m_step = (!es && !er && a == key(0)) ? 1 : 0;
      end else if (a == key(m_step)) m_step++;
      else m_step = (a == key(0)) ? 1 : 0;
    end
    if (es || er) m_hz = 1;
    else if (m_hz == 1 && busy) m_hz = 2;
    else if (m_hz == 2 && !busy) m_hz = 0;
    @(negedge clk);
    check(tag, "store_cmd", store_cmd, es);
    check(tag, "recall_cmd", recall_cmd, er);
    check(tag, "bus_hiz", bus_hiz, m_hz != 0);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cycle(0, 13'h0, 0, 0, tag);
  endtask

  task automatic prefix(int upto, string tag);
    for (int i = 0; i < upto; i++) cycle(1, key(i), 0, 0, tag);
  endtask

  // Let the controller run: busy for n cycles, then release.
  task automatic busy_run(int n, string tag);
    cycle(0, 13'h0, 0, 0, tag);
    for (int i = 0; i < n; i++) cycle(1, key(0), 0, 1, tag);
    cycle(0, 13'h0, 0, 0, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", "store_cmd", store_cmd, 0);
    check("R9", "recall_cmd", recall_cmd, 0);
    check("R9", "bus_hiz", bus_hiz, 0);
    rst_n = 1'b1;
    idle(2, "R9");

    // R1: store key, then controller busy window (R5)
    prefix(5, "R1");
    cycle(1, key(5), 0, 0, "R1");
    idle(2, "R5");
    busy_run(4, "R5");

    // R2: recall key
    prefix(5, "R2");
    cycle(1, key(6), 0, 0, "R2");
    busy_run(2, "R5");

    // R3: write at step 4 aborts, completing after it gives nothing
    prefix(3, "R3");
    cycle(1, key(3), 1, 0, "R3");
    cycle(1, key(4), 0, 0, "R3");
    cycle(1, key(5), 0, 0, "R3");
    // R3: write at the sixth position
    prefix(5, "R3");
    cycle(1, key(5), 1, 0, "R3");
    idle(1, "R3");

    // R4: wrong read aborts
    prefix(4, "R4");
    cycle(1, 13'h0123, 0, 0, "R4");
    cycle(1, key(4), 0, 0, "R4");
    cycle(1, key(5), 0, 0, "R4");
    // R4: stray 0x0000 at step five restarts as step one
    prefix(4, "R4");
    cycle(1, key(0), 0, 0, "R4");
    for (int i = 1; i < 5; i++) cycle(1, key(i), 0, 0, "R4");
    cycle(1, key(5), 0, 0, "R4");
    busy_run(2, "R5");
    // R4: wrong sixth read at 0x0000 restarts too
    prefix(5, "R4");
    cycle(1, key(0), 0, 0, "R4");
    for (int i = 1; i < 5; i++) cycle(1, key(i), 0, 0, "R4");
    cycle(1, key(6), 0, 0, "R4");
    busy_run(1, "R5");

    // R8: gaps between reads
    for (int i = 0; i < 5; i++) begin
      cycle(1, key(i), 0, 0, "R8");
      idle(i + 1, "R8");
    end
    cycle(1, key(5), 0, 0, "R8");
    busy_run(3, "R5");

    // R7: busy cut in the middle, then the rest of the key gives nothing
    prefix(3, "R7");
    cycle(1, key(3), 0, 1, "R7");
    cycle(1, key(3), 0, 0, "R7");
    cycle(1, key(4), 0, 0, "R7");
    cycle(1, key(5), 0, 0, "R7");
    // R7: sixth read during busy issues nothing
    prefix(5, "R7");
    cycle(1, key(6), 0, 1, "R7");
    idle(1, "R7");

    // R6: back-to-back keys, pulses stay single and exclusive
    prefix(5, "R6");
    cycle(1, key(5), 0, 0, "R6");
    prefix(5, "R6");
    cycle(1, key(6), 0, 0, "R6");
    busy_run(2, "R6");

    // Constrained random mix
    begin
      int brun = 0;
      for (int n = 0; n < 6000; n++) begin
        int r;
        logic [12:0] a;
        bit v, wr, busy;
        r = $urandom % 20;
        if (r < 13) a = (m_step == 5) ? key(5 + ($urandom % 2)) : key(m_step);
        else if (r < 15) a = key(0);
        else if (r < 17) a = key($urandom % 7);
        else a = 13'($urandom);
        v  = ($urandom % 5) != 0;
        wr = ($urandom % 25) == 0;
        if (brun > 0) begin busy = 1; brun--; end
        else busy = ($urandom % 60) == 0;
        cycle(v, a, wr, busy, (m_step == 5) ? "R1/R2" : "R4");
        if (m_hz == 1 && brun == 0) brun = 1 + ($urandom % 4);
      end
    end
    idle(3, "R6");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule